// File: doc/BRIEF.md
# Line-Locked Clock Coast Window Generator

This block decides when a line-locked clock generator must stop following horizontal sync and hold its last frequency ("coast"). It merges two sources into one active-high coast signal. The first is an external coast pin whose active level is either detected by the block or forced by a user setting. The second is a pre-coast window, generated internally, that opens a programmable number of lines before the next vertical sync is due. This covers the equalization pulses that would otherwise disturb the phase detector.

The block counts horizontal sync rising edges between successive vertical sync rising edges, which gives the frame length. From that length it predicts where the next vertical sync will fall and raises coast early by the programmed number of lines. While coast is high, the horizontal sync passed to the phase detector is held low.

Top module: `coast_window_gen`

## Requirements
- R1: When the effective coast polarity is active high (1), a high level on the coast pin asserts `coast_o` and a low level does not.
- R2: When the effective coast polarity is active low (0), a low level on the coast pin asserts `coast_o` and a high level does not.
- R3: With `pol_ovr_i` = 1 the effective polarity equals `pol_user_i`. With `pol_ovr_i` = 0 it equals the detected polarity.
- R4: On each vertical sync rising edge, the detected polarity becomes the inverse of the coast pin level sampled in that cycle. After reset the detected polarity is active high.
- R5: `hsync_gated_o` is low whenever `coast_o` is high and equals `hsync_i` otherwise.
- R6: The frame length N is the number of horizontal sync rising edges between two vertical sync rising edges. With pre-coast P (1 ≤ P < N), `coast_o` goes high in the cycle after the (N−P)-th horizontal sync rising edge of a frame.
- R7: The pre-coast window closes in the cycle after a vertical sync rising edge (for P < N).
- R8: P = 0 produces no pre-coast window. P ≥ N keeps the window open for the whole frame.
- R9: No pre-coast window is produced until a full frame, bounded by two vertical sync rising edges, has been measured after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_i | input | 1 | Horizontal sync, active high |
| vsync_i | input | 1 | Separated vertical sync, active high |
| coast_pin_i | input | 1 | External coast request, polarity selectable |
| pol_ovr_i | input | 1 | 1: use user polarity, 0: use detected polarity |
| pol_user_i | input | 1 | User coast polarity, 1 = active high |
| precoast_i | input | PRE_W | Pre-coast lead in lines |
| coast_o | output | 1 | Internal coast, active high |
| hsync_gated_o | output | 1 | Horizontal sync to the phase detector, low during coast |

## Verification
The hardest situation to reach is the pre-coast window itself. It exists only after two vertical sync edges have framed a measured line count, and its opening line depends on the relation between P and the stored N. The stimulus therefore drives whole frames of eight lines. The first frame is checked to show no window, and the later frames switch P between 3, 1, 0 and 8, so that each line of each frame can be compared against the window predicted from N and P. Detected polarity is reached by pulsing vertical sync while the coast pin is held high.

// File: rtl/coast_pkg.sv
package coast_pkg;
   typedef enum logic {
      POL_ACT_LOW  = 1'b0,
      POL_ACT_HIGH = 1'b1
   } coast_pol_e;
endpackage

// File: rtl/cw_input_sync.sv
module cw_input_sync #(
   parameter int STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hs_i,
   input  logic vs_i,
   input  logic pin_i,
   output logic hs_o,
   output logic vs_o,
   output logic pin_o
);
   localparam int NSIG = 3;

   if (STAGES < 0 || STAGES > 4) begin : g_bad
      $error("cw_input_sync: STAGES must be 0..4");
   end

   if (STAGES == 0) begin : g_pass
      assign hs_o  = hs_i;
      assign vs_o  = vs_i;
      assign pin_o = pin_i;
   end else begin : g_sync
      logic [NSIG-1:0] sr [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) sr[i] <= '0;
         end else begin
            sr[0] <= {pin_i, vs_i, hs_i};
            for (int i = 1; i < STAGES; i++) sr[i] <= sr[i-1];
         end
      end
      assign hs_o  = sr[STAGES-1][0];
      assign vs_o  = sr[STAGES-1][1];
      assign pin_o = sr[STAGES-1][2];
   end
endmodule

// File: rtl/cw_polarity_arb.sv
module cw_polarity_arb
   import coast_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       vs_rise,
   input  logic       pin,
   input  logic       ovr,
   input  logic       user_pol,
   output coast_pol_e det_pol_o,
   output coast_pol_e eff_pol_o,
   output logic       ext_coast_o
);
   coast_pol_e det_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       det_q <= POL_ACT_HIGH;
      else if (vs_rise) det_q <= coast_pol_e'(~pin);
   end

   assign det_pol_o   = det_q;
   assign eff_pol_o   = ovr ? coast_pol_e'(user_pol) : det_q;
   assign ext_coast_o = (pin == logic'(eff_pol_o));
endmodule

// File: rtl/cw_frame_predictor.sv
module cw_frame_predictor #(
   parameter int LINE_W = 11,
   parameter int PRE_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hs_rise,
   input  logic              vs_rise,
   input  logic [PRE_W-1:0]  precoast,
   output logic              valid_o,
   output logic [LINE_W-1:0] total_o,
   output logic              win_o
);
   localparam logic [LINE_W-1:0] CNT_MAX = {LINE_W{1'b1}};
   localparam int                PAD     = LINE_W - PRE_W;

   logic              started_q;
   logic              valid_q;
   logic [LINE_W-1:0] cnt_q;
   logic [LINE_W-1:0] total_q;
   logic [LINE_W-1:0] pre_ext;
   logic [LINE_W-1:0] thr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         started_q <= 1'b0;
         valid_q   <= 1'b0;
         cnt_q     <= '0;
         total_q   <= '0;
      end else if (vs_rise) begin
         started_q <= 1'b1;
         cnt_q     <= '0;
         if (started_q) begin
            valid_q <= 1'b1;
            total_q <= cnt_q;
         end
      end else if (hs_rise && started_q && cnt_q != CNT_MAX) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   if (PAD > 0) begin : g_pad
      assign pre_ext = {{PAD{1'b0}}, precoast};
   end else begin : g_nopad
      assign pre_ext = precoast;
   end

   assign thr     = (pre_ext >= total_q) ? '0 : (total_q - pre_ext);
   assign win_o   = valid_q && (precoast != '0) && (cnt_q >= thr);
   assign valid_o = valid_q;
   assign total_o = total_q;
endmodule

// File: rtl/coast_window_gen.sv
module coast_window_gen
   import coast_pkg::*;
#(
   parameter int LINE_W    = 11,
   parameter int PRE_W     = 8,
   parameter int IN_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hsync_i,
   input  logic             vsync_i,
   input  logic             coast_pin_i,
   input  logic             pol_ovr_i,
   input  logic             pol_user_i,
   input  logic [PRE_W-1:0] precoast_i,
   output logic             coast_o,
   output logic             hsync_gated_o
);
   if (LINE_W < PRE_W) begin : g_chk_w
      $error("coast_window_gen: LINE_W must be >= PRE_W");
   end
   if (PRE_W < 1) begin : g_chk_p
      $error("coast_window_gen: PRE_W must be >= 1");
   end

   logic              hs_s, vs_s, pin_s;
   logic              hs_q, vs_q;
   logic              hs_rise, vs_rise;
   coast_pol_e        det_pol, eff_pol;
   logic              ext_coast;
   logic              frame_valid;
   logic [LINE_W-1:0] frame_lines;
   logic              pre_win;

   cw_input_sync #(.STAGES(IN_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .hs_i(hsync_i), .vs_i(vsync_i), .pin_i(coast_pin_i),
      .hs_o(hs_s), .vs_o(vs_s), .pin_o(pin_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_q <= 1'b0;
         vs_q <= 1'b0;
      end else begin
         hs_q <= hs_s;
         vs_q <= vs_s;
      end
   end

   assign hs_rise = hs_s & ~hs_q;
   assign vs_rise = vs_s & ~vs_q;

   cw_polarity_arb u_pol (
      .clk(clk), .rst_n(rst_n),
      .vs_rise(vs_rise), .pin(pin_s),
      .ovr(pol_ovr_i), .user_pol(pol_user_i),
      .det_pol_o(det_pol), .eff_pol_o(eff_pol),
      .ext_coast_o(ext_coast)
   );

   cw_frame_predictor #(.LINE_W(LINE_W), .PRE_W(PRE_W)) u_pred (
      .clk(clk), .rst_n(rst_n),
      .hs_rise(hs_rise), .vs_rise(vs_rise),
      .precoast(precoast_i),
      .valid_o(frame_valid), .total_o(frame_lines),
      .win_o(pre_win)
   );

   assign coast_o       = ext_coast | pre_win;
   assign hsync_gated_o = hs_s & ~coast_o;
endmodule

// File: rtl/coast_window_chk.sv
module coast_window_chk #(
   parameter int LINE_W = 11,
   parameter int PRE_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hs_s,
   input logic              pin_s,
   input logic              pol_ovr_i,
   input logic              pol_user_i,
   input logic [PRE_W-1:0]  precoast_i,
   input logic              coast_o,
   input logic              hsync_gated_o,
   input logic              vs_rise,
   input logic              det_pol,
   input logic              pre_win,
   input logic              frame_valid,
   input logic [LINE_W-1:0] frame_lines
);
   AST_GATED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      coast_o |-> !hsync_gated_o); // R5
   AST_GATED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      !coast_o |-> (hsync_gated_o == hs_s)); // R5
   AST_USER_POL: assert property (@(posedge clk) disable iff (!rst_n)
      (pol_ovr_i && !pre_win) |-> (coast_o == (pin_s == pol_user_i))); // R3
   AST_DET_POL: assert property (@(posedge clk) disable iff (!rst_n)
      vs_rise |=> (det_pol == !$past(pin_s))); // R4
   AST_NO_EARLY_WIN: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_valid |-> !pre_win); // R9
   AST_ZERO_PRE: assert property (@(posedge clk) disable iff (!rst_n)
      (precoast_i == '0) |-> !pre_win); // R8
   AST_WIN_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(vs_rise) && (LINE_W'(precoast_i) < frame_lines)) |-> !pre_win); // R7
endmodule

bind coast_window_gen coast_window_chk #(.LINE_W(LINE_W), .PRE_W(PRE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .hs_s(hs_s), .pin_s(pin_s),
   .pol_ovr_i(pol_ovr_i), .pol_user_i(pol_user_i), .precoast_i(precoast_i),
   .coast_o(coast_o), .hsync_gated_o(hsync_gated_o),
   .vs_rise(vs_rise), .det_pol(det_pol), .pre_win(pre_win),
   .frame_valid(frame_valid), .frame_lines(frame_lines)
);

// File: tb/tb_coast_window_gen.sv
`timescale 1ns/1ps
module tb_coast_window_gen;
   localparam int PRE_W = 8;
   localparam int NV    = 8;
   // vector: {ovr, user, pin, hs, exp_coast, exp_gated}
   localparam logic [5:0] VEC [NV] = '{
      6'b0_0_0_1_0_1, 6'b0_0_1_1_1_0, 6'b1_1_1_1_1_0, 6'b1_1_0_1_0_1,
      6'b1_0_0_1_1_0, 6'b1_0_1_1_0_1, 6'b1_0_0_0_1_0, 6'b0_1_0_0_0_0
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hsync_i = 1'b0, vsync_i = 1'b0, coast_pin_i = 1'b0;
   logic pol_ovr_i = 1'b0, pol_user_i = 1'b1;
   logic [PRE_W-1:0] precoast_i = 8'd1;
   logic coast_o, hsync_gated_o;
   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   coast_window_gen dut (
      .clk(clk), .rst_n(rst_n), .hsync_i(hsync_i), .vsync_i(vsync_i),
      .coast_pin_i(coast_pin_i), .pol_ovr_i(pol_ovr_i), .pol_user_i(pol_user_i),
      .precoast_i(precoast_i), .coast_o(coast_o), .hsync_gated_o(hsync_gated_o)
   );

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input logic h, input logic v, input logic p);
      @(negedge clk);
      hsync_i = h; vsync_i = v; coast_pin_i = p;
      #2;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      hsync_i = 1'b0; vsync_i = 1'b0; coast_pin_i = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   function automatic logic win(input int c, input int n, input int p, input logic v);
      int thr;
      thr = (p >= n) ? 0 : n - p;
      return v && (p != 0) && (c >= thr);
   endfunction

   // one vertical sync pulse followed by n lines of 4 cycles each
   task automatic frame(input int n, input int p, input logic v);
      precoast_i = PRE_W'(p);
      step(1'b0, 1'b1, 1'b0);
      step(1'b0, 1'b0, 1'b0);
      check(v ? "R7 closed after vsync" : "R9 no window", coast_o, win(0, n, p, v));
      for (int k = 1; k <= n; k++) begin
         step(1'b1, 1'b0, 1'b0);
         check("R5 gated hsync", hsync_gated_o, !win(k-1, n, p, v));
         step(1'b0, 1'b0, 1'b0);
         check(v ? "R6 R8 window" : "R9 no window", coast_o, win(k, n, p, v));
         step(1'b0, 1'b0, 1'b0);
         step(1'b0, 1'b0, 1'b0);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      do_reset();
      // reset state: detected polarity active high, no window (R4)
      step(1'b1, 1'b0, 1'b0);
      check("R4 reset coast", coast_o, 1'b0);
      check("R5 reset gated", hsync_gated_o, 1'b1);

      // vector table: polarity selection and gating, R1 R2 R3 R5
      for (int i = 0; i < NV; i++) begin
         pol_ovr_i  = VEC[i][5];
         pol_user_i = VEC[i][4];
         step(VEC[i][2], 1'b0, VEC[i][3]);
         check("R1 R2 R3 coast", coast_o, VEC[i][1]);
         check("R5 gated", hsync_gated_o, VEC[i][0]);
      end

      // detected polarity: vsync edge while pin high -> active low (R4)
      do_reset();
      pol_ovr_i = 1'b0; pol_user_i = 1'b1;
      step(1'b0, 1'b1, 1'b1);
      step(1'b0, 1'b0, 1'b1);
      check("R4 detect low, pin high", coast_o, 1'b0);
      step(1'b0, 1'b0, 1'b0);
      check("R2 active low pin low", coast_o, 1'b1);
      pol_ovr_i = 1'b1;
      step(1'b0, 1'b0, 1'b0);
      check("R3 user overrides detected", coast_o, 1'b0);
      pol_ovr_i = 1'b0;
      step(1'b0, 1'b1, 1'b0);
      step(1'b0, 1'b0, 1'b1);
      check("R4 detect high, pin high", coast_o, 1'b1);

      // pre-coast frames of 8 lines
      do_reset();
      pol_ovr_i = 1'b0;
      frame(8, 3, 1'b0);   // R9 first frame only measured
      frame(8, 3, 1'b1);   // R6 R7
      frame(8, 1, 1'b1);   // R6
      frame(8, 0, 1'b1);   // R8 zero lead
      frame(8, 8, 1'b1);   // R8 whole frame
      step(1'b0, 1'b0, 1'b0);
      check("R8 whole frame still open", coast_o, 1'b1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule